// File: doc/BRIEF.md
# Pin Change Interrupt Controller

This block watches a set of general-purpose input pins, by default 28, and raises an interrupt request when any enabled pin toggles. The pins are split into groups of up to eight. With the defaults there are three groups of eight pins and one final group of four. Each pin is brought into the clock domain through a synchroniser. A transition in either direction on a pin whose mask bit is set marks that pin's group as pending by setting the group's flag.

Software programs one mask register per group and a group-enable register. It reads the pending flags over a small synchronous register port. A request output for each group is raised while that group's flag and enable bit are both set and the global interrupt enable input is high. A flag is sticky. It is cleared when software writes a one to it, or when the interrupt logic pulses that group's acknowledge input on entering the service routine. If a new pin change arrives in the same cycle as a clear, the flag stays set, so no change is lost.

Top module: `pin_change_irq_ctrl`

## Requirements
- R1: After reset, all flags, masks and enable bits are zero, every read returns 0x00 and all request outputs are low.
- R2: Pins map to groups in blocks of eight: group 0 covers pins 7:0, group 1 pins 15:8, group 2 pins 23:16 and group 3 pins 27:24. A rising or falling change on a pin whose mask bit is set sets that group's flag (bit g of the flag register) on the third rising clock edge after the pin changes.
- R3: A change on a pin whose mask bit is clear leaves every flag unchanged.
- R4: Writing the flag register (address 0x3B) clears each flag whose data bit is one and leaves each flag whose data bit is zero unchanged.
- R5: A one-cycle pulse on ack_i[g] clears flag g.
- R6: When a flag set event and a clear (a write of one or an acknowledge) act on the same clock edge, the flag ends up set.
- R7: irq_o[g] is high exactly when flag g, enable bit g and gie_i are all high.
- R8: Bits 7:4 of the flag register (0x3B), of the enable register (0x68) and of the group-3 mask register always read as zero.
- R9: The mask registers sit at 0x6B (group 0), 0x6C (group 1), 0x6D (group 2) and 0x6A (group 3). Bit n of a mask register enables pin 8g+n. Read data appears on bus_rdata_o in the cycle after bus_re_i and is 0x00 otherwise. Unmapped addresses read 0x00.
- R10: A set flag stays set through further pin changes and idle cycles until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | 28 | Asynchronous input pins watched for changes |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | 4 | Per-group service acknowledge pulse, clears the flag |
| bus_addr_i | input | 8 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_we_i | input | 1 | Write strobe |
| bus_re_i | input | 1 | Read strobe |
| bus_rdata_o | output | 8 | Registered read data |
| irq_o | output | 4 | Per-group interrupt request |

## Verification
The hardest case to reach from the ports is a set and a clear landing on the same clock edge. The pin change is delayed by the synchroniser and the change detector. The bench therefore drives the pin toggle, counts exactly two falling edges, and then presents the flag write-one or the acknowledge pulse, so that it meets the detected change on the third rising edge. A table of single-pin toggles covers both edge directions, the first and last pin of every group, and masked-off pins with their neighbours enabled.

// File: rtl/pcint_pkg.sv
`timescale 1ns/1ps
package pcint_pkg;
   localparam int unsigned BUS_W = 8;

   // number of pins in group g when pins are packed into groups of gw
   function automatic int unsigned grp_width(input int unsigned npins,
                                             input int unsigned gw,
                                             input int unsigned g);
      int unsigned rest;
      rest = npins - g * gw;
      return (rest < gw) ? rest : gw;
   endfunction

   function automatic int unsigned grp_count(input int unsigned npins,
                                             input int unsigned gw);
      return (npins + gw - 1) / gw;
   endfunction
endpackage

// File: rtl/pcint_sync.sv
`timescale 1ns/1ps
module pcint_sync #(
   parameter int unsigned WIDTH  = 28,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din_i,
   output logic [WIDTH-1:0] change_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pcint_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("pcint_sync: WIDTH must be at least 1");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      logic              prev_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
         end else begin
            chain_q <= {chain_q[STAGES-2:0], din_i[i]};
            prev_q  <= chain_q[STAGES-1];
         end
      end

      // either edge of the synchronised value
      assign change_o[i] = chain_q[STAGES-1] ^ prev_q;
   end
endmodule

// File: rtl/pcint_group_flag.sv
`timescale 1ns/1ps
module pcint_group_flag #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] change_i,
   input  logic [WIDTH-1:0] mask_i,
   input  logic             clr_i,
   output logic             flag_o
);
   if (WIDTH < 1 || WIDTH > pcint_pkg::BUS_W) begin : g_bad_width
      $error("pcint_group_flag: WIDTH out of range");
   end

   logic set_evt;
   logic flag_q;

   assign set_evt = |(change_i & mask_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (set_evt) flag_q <= 1'b1;
      else if (clr_i)   flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt |=> flag_q); // R6
   AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr_i) |=> flag_q); // R10
   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_evt) |=> !flag_q); // R4
   AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q && !(|(change_i & mask_i))) |=> !flag_q); // R3
endmodule

// File: rtl/pcint_regs.sv
`timescale 1ns/1ps
module pcint_regs #(
   parameter int unsigned NUM_PINS    = 28,
   parameter int unsigned GROUP_W     = 8,
   parameter int unsigned NUM_GROUPS  = 4,
   parameter logic [7:0]  FLAG_ADDR   = 8'h3B,
   parameter logic [7:0]  ENABLE_ADDR = 8'h68,
   parameter logic [7:0]  MASK_BASE   = 8'h6A
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [7:0]            addr_i,
   input  logic [7:0]            wdata_i,
   input  logic                  we_i,
   input  logic                  re_i,
   output logic [7:0]            rdata_o,
   input  logic [NUM_GROUPS-1:0] flags_i,
   output logic [NUM_GROUPS-1:0] en_o,
   output logic [NUM_GROUPS-1:0] wclr_o,
   output logic [NUM_PINS-1:0]   mask_o
);
   localparam int unsigned BW = pcint_pkg::BUS_W;

   if (GROUP_W > BW || NUM_GROUPS > BW) begin : g_bad_fit
      $error("pcint_regs: groups or group width exceed the data bus");
   end

   // the last group's mask sits at MASK_BASE, group 0 follows it
   function automatic logic [7:0] mask_addr(input int unsigned g);
      return MASK_BASE + 8'((g + 1) % NUM_GROUPS);
   endfunction

   logic [GROUP_W-1:0]    mask_arr [NUM_GROUPS];
   logic [NUM_GROUPS-1:0] en_q;
   logic [BW-1:0]         rd_mux;
   logic [BW-1:0]         rdata_q;

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_mask
      localparam int unsigned GW = pcint_pkg::grp_width(NUM_PINS, GROUP_W, g);
      localparam logic [GROUP_W-1:0] KEEP = {GROUP_W{1'b1}} >> (GROUP_W - GW);
      logic [GROUP_W-1:0] q;

      if (mask_addr(g) == FLAG_ADDR || mask_addr(g) == ENABLE_ADDR) begin : g_clash
         $error("pcint_regs: mask address collides with another register");
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             q <= '0;
         else if (we_i && addr_i == mask_addr(g)) q <= wdata_i[GROUP_W-1:0] & KEEP;
      end

      assign mask_arr[g]               = q;
      assign mask_o[g*GROUP_W +: GW]   = q[GW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              en_q <= '0;
      else if (we_i && addr_i == ENABLE_ADDR)  en_q <= wdata_i[NUM_GROUPS-1:0];
   end

   assign en_o   = en_q;
   assign wclr_o = (we_i && addr_i == FLAG_ADDR) ? wdata_i[NUM_GROUPS-1:0] : '0;

   always_comb begin
      rd_mux = '0;
      if (addr_i == FLAG_ADDR)   rd_mux[NUM_GROUPS-1:0] = flags_i;
      if (addr_i == ENABLE_ADDR) rd_mux[NUM_GROUPS-1:0] = en_q;
      for (int g = 0; g < NUM_GROUPS; g++) begin
         if (addr_i == mask_addr(g)) rd_mux[GROUP_W-1:0] = mask_arr[g];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata_q <= '0;
      else        rdata_q <= re_i ? rd_mux : '0;
   end

   assign rdata_o = rdata_q;

   AST_RSVD_FLAG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (re_i && addr_i == FLAG_ADDR) |=> (rdata_o[BW-1:NUM_GROUPS] == '0)); // R8
   AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !re_i |=> (rdata_o == '0)); // R9
endmodule

// File: rtl/pin_change_irq_ctrl.sv
`timescale 1ns/1ps
module pin_change_irq_ctrl #(
   parameter int unsigned NUM_PINS    = 28,
   parameter int unsigned GROUP_W     = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [7:0]  FLAG_ADDR   = 8'h3B,
   parameter logic [7:0]  ENABLE_ADDR = 8'h68,
   parameter logic [7:0]  MASK_BASE   = 8'h6A,
   localparam int unsigned NG = pcint_pkg::grp_count(NUM_PINS, GROUP_W)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pins_i,
   input  logic                gie_i,
   input  logic [NG-1:0]       ack_i,
   input  logic [7:0]          bus_addr_i,
   input  logic [7:0]          bus_wdata_i,
   input  logic                bus_we_i,
   input  logic                bus_re_i,
   output logic [7:0]          bus_rdata_o,
   output logic [NG-1:0]       irq_o
);
   if (NUM_PINS < 1 || GROUP_W < 1) begin : g_bad_size
      $error("pin_change_irq_ctrl: empty pin set");
   end

   logic [NUM_PINS-1:0] change;
   logic [NUM_PINS-1:0] mask;
   logic [NG-1:0]       flags;
   logic [NG-1:0]       en;
   logic [NG-1:0]       wclr;

   pcint_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) i_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .din_i   (pins_i),
      .change_o(change)
   );

   pcint_regs #(
      .NUM_PINS   (NUM_PINS),
      .GROUP_W    (GROUP_W),
      .NUM_GROUPS (NG),
      .FLAG_ADDR  (FLAG_ADDR),
      .ENABLE_ADDR(ENABLE_ADDR),
      .MASK_BASE  (MASK_BASE)
   ) i_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr_i (bus_addr_i),
      .wdata_i(bus_wdata_i),
      .we_i   (bus_we_i),
      .re_i   (bus_re_i),
      .rdata_o(bus_rdata_o),
      .flags_i(flags),
      .en_o   (en),
      .wclr_o (wclr),
      .mask_o (mask)
   );

   for (genvar g = 0; g < NG; g++) begin : g_grp
      localparam int unsigned GW = pcint_pkg::grp_width(NUM_PINS, GROUP_W, g);
      pcint_group_flag #(.WIDTH(GW)) i_flag (
         .clk     (clk),
         .rst_n   (rst_n),
         .change_i(change[g*GROUP_W +: GW]),
         .mask_i  (mask[g*GROUP_W +: GW]),
         .clr_i   (wclr[g] | ack_i[g]),
         .flag_o  (flags[g])
      );
      assign irq_o[g] = flags[g] & en[g] & gie_i;
   end

   AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i == '1 && change == '0) |=> (irq_o == '0)); // R5
endmodule

// File: tb/test_pin_change_irq_ctrl.sv
`timescale 1ns/1ps
module test_pin_change_irq_ctrl;
   localparam logic [7:0] FLAG_A = 8'h3B;
   localparam logic [7:0] EN_A   = 8'h68;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [27:0] pins = '0;
   logic        gie = 1'b0;
   logic [3:0]  ack = '0;
   logic [7:0]  addr = '0;
   logic [7:0]  wdata = '0;
   logic        we = 1'b0;
   logic        re = 1'b0;
   logic [7:0]  rdata;
   logic [3:0]  irq;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   pin_change_irq_ctrl i_pin_change_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .pins_i(pins), .gie_i(gie), .ack_i(ack),
      .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_we_i(we), .bus_re_i(re),
      .bus_rdata_o(rdata), .irq_o(irq)
   );

   // {pin[4:0], mask_on, expected flags[3:0]}
   localparam int NV = 14;
   localparam logic [9:0] VEC [NV] = '{
      {5'd0,  1'b1, 4'b0001}, {5'd7,  1'b1, 4'b0001}, {5'd8,  1'b1, 4'b0010},
      {5'd15, 1'b1, 4'b0010}, {5'd16, 1'b1, 4'b0100}, {5'd23, 1'b1, 4'b0100},
      {5'd24, 1'b1, 4'b1000}, {5'd27, 1'b1, 4'b1000}, {5'd5,  1'b0, 4'b0000},
      {5'd26, 1'b0, 4'b0000}, {5'd0,  1'b1, 4'b0001}, {5'd27, 1'b1, 4'b1000},
      {5'd12, 1'b0, 4'b0000}, {5'd19, 1'b1, 4'b0100}
   };

   function automatic logic [7:0] mask_a(input int g);
      return 8'h6A + 8'((g + 1) % 4);
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; re = 1'b1;
      @(negedge clk);
      re = 1'b0;
      d = rdata;
   endtask

   task automatic toggle(input int p);
      @(negedge clk);
      pins[p] = ~pins[p];
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: got 0x00 expected 0x01");
         finish_run();
      end
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(FLAG_A, d); check("R1 flags", d, 8'h00);
      rd(EN_A, d);   check("R1 enable", d, 8'h00);
      for (int g = 0; g < 4; g++) begin
         rd(mask_a(g), d); check("R1 mask", d, 8'h00);
      end
      check("R1 irq", {4'h0, irq}, 8'h00);

      // table walk: R2, R3
      for (int v = 0; v < NV; v++) begin
         int p;
         int grp;
         logic [7:0] m;
         p   = int'(VEC[v][9:5]);
         grp = p / 8;
         for (int g = 0; g < 4; g++) begin
            m = 8'h00;
            if (g == grp) m = VEC[v][4] ? (8'h01 << (p % 8)) : ~(8'h01 << (p % 8));
            wr(mask_a(g), m);
         end
         wr(FLAG_A, 8'h0F);
         toggle(p);
         repeat (3) @(negedge clk);
         rd(FLAG_A, d);
         check(VEC[v][4] ? "R2 vector" : "R3 vector", d, {4'h0, VEC[v][3:0]});
      end

      // R2 timing: flag not yet set after two edges, set after three
      for (int g = 0; g < 4; g++) wr(mask_a(g), 8'hFF);
      wr(FLAG_A, 8'h0F);
      wr(EN_A, 8'h0F); gie = 1'b1;
      toggle(3);
      @(negedge clk); @(negedge clk);
      check("R2 not before third edge", {4'h0, irq}, 8'h00);
      @(negedge clk);
      check("R2 third edge", {4'h0, irq}, 8'h01);

      // R8 reserved bits, R9 addresses
      wr(mask_a(3), 8'hFF); rd(mask_a(3), d); check("R8 mask3 reserved", d, 8'h0F);
      rd(EN_A, d);          check("R8 enable reserved", d, 8'h0F);
      rd(FLAG_A, d);        check("R8 flag reserved", d, 8'h01);
      wr(mask_a(1), 8'hA5); rd(8'h6C, d); check("R9 group1 mask at 0x6C", d, 8'hA5);
      rd(8'h50, d);         check("R9 unmapped read", d, 8'h00);
      @(negedge clk);       check("R9 idle rdata", rdata, 8'h00);
      wr(mask_a(1), 8'hFF);

      // R4 write-one clears, zero keeps
      toggle(9);
      repeat (3) @(negedge clk);
      rd(FLAG_A, d); check("R4 setup", d, 8'h03);
      wr(FLAG_A, 8'h01);
      rd(FLAG_A, d); check("R4 selective clear", d, 8'h02);

      // R5 acknowledge clears
      @(negedge clk); ack = 4'b0010;
      @(negedge clk); ack = 4'b0000;
      rd(FLAG_A, d); check("R5 ack clear", d, 8'h00);

      // R10 sticky through more changes
      toggle(20); toggle(20);
      repeat (8) @(negedge clk);
      rd(FLAG_A, d); check("R10 sticky", d, 8'h04);
      wr(FLAG_A, 8'h04);

      // R7 request gating
      wr(EN_A, 8'h00);
      toggle(25);
      repeat (3) @(negedge clk);
      check("R7 enable off", {4'h0, irq}, 8'h00);
      wr(EN_A, 8'h08); gie = 1'b0;
      @(negedge clk);
      check("R7 gie off", {4'h0, irq}, 8'h00);
      gie = 1'b1;
      @(negedge clk);
      check("R7 all on", {4'h0, irq}, 8'h08);
      wr(FLAG_A, 8'h08);
      check("R7 flag cleared", {4'h0, irq}, 8'h00);

      // R6 set wins over write-one on the same edge
      toggle(2);
      repeat (2) @(negedge clk);
      addr = FLAG_A; wdata = 8'h01; we = 1'b1;
      @(negedge clk); we = 1'b0;
      rd(FLAG_A, d); check("R6 set beats write clear", d, 8'h01);

      // R6 set wins over acknowledge on the same edge
      toggle(2);
      repeat (2) @(negedge clk);
      ack = 4'b0001;
      @(negedge clk); ack = 4'b0000;
      rd(FLAG_A, d); check("R6 set beats ack", d, 8'h01);

      done = 1'b1;
      finish_run();
   end
endmodule